// File: doc/BRIEF.md
# Buffered-Update PWM Generator

This block is a single pulse-width generator built around one down-counting time base. It has a period register and two compare registers, A and B. The counter runs from the active period value down to zero and then reloads. The output rises on each reload. It falls when the count equals the active compare A value. Compare B drives a separate match flag. Because both compares are tested against the same counter, they always share one time base.

Software writes each register through a write port into a shadow copy. A per-group policy decides when the shadow moves into the active value. The period has its own policy, and the two compares share a second one. An immediate policy applies the write on the next cycle. A local policy holds it until the counter reaches zero. A global policy holds it until a global request has been armed and a zero has then followed. Under the buffered policies, both compare values move to active at the same zero. A PWM cycle therefore never runs on one new compare and one old compare. Several chips' generators can share the global request to switch their values on the same cycle boundary.

Top module: `pwm_gen_buffered`

## Requirements
- R1: During and right after reset, the count equals the reset period value `RST_LOAD`, both compares are zero, both policies are immediate, and `pwm_out`, `match_b` and `glb_pending` are low.
- R2: When the count is not zero, it falls by one each cycle. When the count is zero, the next count is the active period value, so one PWM cycle lasts period+1 clock cycles.
- R3: `pwm_out` is high in the cycle after the count is zero. It is low in the cycle after the count equals a non-zero compare A. Within a full cycle, it is high for period−A+1 cycles when 1 ≤ A ≤ period, and for every cycle when A is 0 or greater than the period.
- R4: `match_b` is high exactly in the cycles where the count equals the active compare B.
- R5: Under the immediate policy (code 0), a written value becomes active on the next cycle. A new period value is used at the next reload, and the current countdown is not cut short.
- R6: Under the local policy (code 1), written values stay pending until the count reaches zero. Both pending compare values then become active at that same zero.
- R7: Under the global policy (code 2), pending values commit only at a zero that occurs while a global request is armed. A zero with no armed request does not commit them, and an armed request before that zero does not commit them either.
- R8: A one-cycle `glb_req` pulse sets `glb_pending` on the next cycle. `glb_pending` clears after the next zero, unless a new request arrives in that same cycle.
- R9: If several writes reach one register while it is pending, only the last written value commits.
- R10: Register map on `wr_addr`: 0 is control, with bits [1:0] the period policy and bits [3:2] the compare policy. 1 is the period, 2 is compare A and 3 is compare B. Policy code 3 behaves as immediate.
- R11: The period policy and the compare policy act independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select (0 control, 1 period, 2 compare A, 3 compare B) |
| wr_data | input | CNT_W | Write data |
| glb_req | input | 1 | One-cycle global update request |
| pwm_out | output | 1 | PWM output |
| match_b | output | 1 | Compare B match flag |
| glb_pending | output | 1 | Global request armed, commit not yet done |
| cnt_out | output | CNT_W | Current counter value |

## Verification
The bench measures the high time and the length of whole PWM cycles after a set of directed write patterns. It writes under the immediate policy from reset values, and it changes the period in the middle of a cycle. It writes both compares under the local policy, and under the global policy it writes with a zero but no request, then with a request but no zero yet. It repeats writes under a pending commit, and it mixes the two policies. Mid-cycle samples of `pwm_out` and `match_b` at chosen counts show whether old or new values are active. This separates a commit that fires too early, at the wrong zero or without an armed request from one that keeps a stale value. Period counts separate a load that applies at once from one that waits for the reload.

// File: rtl/pwm_buf_pkg.sv
package pwm_buf_pkg;

   typedef enum logic [1:0] {
      POL_IMM    = 2'd0,
      POL_LOCAL  = 2'd1,
      POL_GLOBAL = 2'd2,
      POL_RSVD   = 2'd3
   } commit_pol_e;

   localparam int ADDR_W     = 2;
   localparam int POL_W      = 2;
   localparam int CTRL_W     = 2 * POL_W;

   localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
   localparam logic [ADDR_W-1:0] A_LOAD = 2'd1;
   localparam logic [ADDR_W-1:0] A_CMPA = 2'd2;
   localparam logic [ADDR_W-1:0] A_CMPB = 2'd3;

   // Reserved code falls back to immediate behaviour.
   function automatic commit_pol_e pol_decode(input logic [POL_W-1:0] f);
      commit_pol_e p;
      case (f)
         2'd1:    p = POL_LOCAL;
         2'd2:    p = POL_GLOBAL;
         default: p = POL_IMM;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/pwm_shadow_group.sv
module pwm_shadow_group
   import pwm_buf_pkg::*;
#(
   parameter int             N       = 2,
   parameter int             W       = 16,
   parameter logic [N*W-1:0] RST_VEC = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [N-1:0]   wr_en,
   input  logic [W-1:0]   wr_data,
   input  commit_pol_e    pol,
   input  logic           zero_evt,
   input  logic           glb_arm,
   output logic [N*W-1:0] active_q,
   output logic [N*W-1:0] active_nxt
);

   localparam int TOT_W = N * W;

   logic [TOT_W-1:0] shadow_q;
   logic             pend_q;
   logic             any_wr;
   logic             commit;
   logic             buffered;

   initial begin
      if (N < 1) $error("pwm_shadow_group: N must be at least 1");
      if (W < 1) $error("pwm_shadow_group: W must be at least 1");
   end

   assign any_wr   = |wr_en;
   assign buffered = (pol != POL_IMM);

   // A whole group moves together, so all members see one commit strobe.
   always_comb begin
      commit = 1'b0;
      if (pend_q) begin
         case (pol)
            POL_LOCAL:  commit = zero_evt;
            POL_GLOBAL: commit = zero_evt && glb_arm;
            default:    commit = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (any_wr && buffered)
         pend_q <= 1'b1;
      else if (commit)
         pend_q <= 1'b0;
   end

   for (genvar i = 0; i < N; i++) begin : g_mem
      always_comb begin
         if (wr_en[i] && !buffered)
            active_nxt[i*W +: W] = wr_data;
         else if (commit)
            active_nxt[i*W +: W] = shadow_q[i*W +: W];
         else
            active_nxt[i*W +: W] = active_q[i*W +: W];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            shadow_q[i*W +: W] <= RST_VEC[i*W +: W];
         else if (wr_en[i])
            shadow_q[i*W +: W] <= wr_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         active_q <= RST_VEC;
      else
         active_q <= active_nxt;
   end

   // R6: no movement of active values under local policy away from zero
   a_r6_local_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (pol == POL_LOCAL && !zero_evt) |=> $stable(active_q));

   // R7: global policy holds unless zero coincides with an armed request
   a_r7_global_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (pol == POL_GLOBAL && !(zero_evt && glb_arm)) |=> $stable(active_q));

   // R5: immediate write lands in the active copy on the next cycle
   a_r5_imm_write : assert property (@(posedge clk) disable iff (!rst_n)
      (pol == POL_IMM && wr_en[0]) |=> (active_q[W-1:0] == $past(wr_data)));

   // R9: a buffered commit carries the latest shadow content
   a_r9_latest_value : assert property (@(posedge clk) disable iff (!rst_n)
      (buffered && commit && !wr_en[0]) |=> (active_q[W-1:0] == shadow_q[W-1:0]));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
   parameter int           W        = 16,
   parameter logic [W-1:0] RST_LOAD = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] reload_val,
   output logic [W-1:0] cnt_q,
   output logic         zero_evt
);

   localparam logic [W-1:0] ONE = W'(1);

   assign zero_evt = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= RST_LOAD;
      else if (zero_evt)
         cnt_q <= reload_val;
      else
         cnt_q <= cnt_q - ONE;
   end

   // R2: decrement by one away from zero
   a_r2_count_down : assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/pwm_edge_out.sv
module pwm_edge_out #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cnt,
   input  logic         zero_evt,
   input  logic [W-1:0] cmp_a,
   input  logic [W-1:0] cmp_b,
   output logic         pwm_q,
   output logic         match_b
);

   logic hit_a;

   assign hit_a   = (cnt == cmp_a);
   assign match_b = (cnt == cmp_b);

   // Reload sets; compare A clears; reload wins when both coincide.
   always_ff @(posedge clk) begin
      if (!rst_n)
         pwm_q <= 1'b0;
      else if (zero_evt)
         pwm_q <= 1'b1;
      else if (hit_a)
         pwm_q <= 1'b0;
   end

   // R3: rising after the zero cycle
   a_r3_high_after_zero : assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |=> pwm_q);

   // R3: falling after a non-zero compare A match
   a_r3_low_after_match : assert property (@(posedge clk) disable iff (!rst_n)
      (!zero_evt && cnt == cmp_a) |=> !pwm_q);

   // R3: no edge between events
   a_r3_hold_between : assert property (@(posedge clk) disable iff (!rst_n)
      (!zero_evt && cnt != cmp_a) |=> $stable(pwm_q));

endmodule

// File: rtl/pwm_gen_buffered.sv
module pwm_gen_buffered
   import pwm_buf_pkg::*;
#(
   parameter int               CNT_W    = 16,
   parameter logic [CNT_W-1:0] RST_LOAD = CNT_W'(999)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [pwm_buf_pkg::ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]         wr_data,
   input  logic                     glb_req,
   output logic                     pwm_out,
   output logic                     match_b,
   output logic                     glb_pending,
   output logic [CNT_W-1:0]         cnt_out
);

   localparam int NCMP = 2;

   if (CNT_W < CTRL_W) begin : g_chk_width
      $error("pwm_gen_buffered: CNT_W must hold the control fields");
   end

   commit_pol_e             load_pol_q;
   commit_pol_e             cmp_pol_q;
   logic                    arm_q;
   logic                    zero_evt;
   logic [CNT_W-1:0]        cnt_q;
   logic [0:0]              load_we;
   logic [NCMP-1:0]         cmp_we;
   logic [CNT_W-1:0]        load_act_q;
   logic [CNT_W-1:0]        load_nxt;
   logic [NCMP*CNT_W-1:0]   cmp_act_q;
   logic [NCMP*CNT_W-1:0]   cmp_nxt;

   // Write decode
   assign load_we[0] = wr_en && (wr_addr == A_LOAD);
   assign cmp_we[0]  = wr_en && (wr_addr == A_CMPA);
   assign cmp_we[1]  = wr_en && (wr_addr == A_CMPB);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         load_pol_q <= POL_IMM;
         cmp_pol_q  <= POL_IMM;
      end else if (wr_en && wr_addr == A_CTRL) begin
         load_pol_q <= pol_decode(wr_data[POL_W-1:0]);
         cmp_pol_q  <= pol_decode(wr_data[2*POL_W-1:POL_W]);
      end
   end

   // Global request: sticky until the zero that consumes it
   always_ff @(posedge clk) begin
      if (!rst_n)
         arm_q <= 1'b0;
      else if (glb_req)
         arm_q <= 1'b1;
      else if (zero_evt)
         arm_q <= 1'b0;
   end

   pwm_shadow_group #(
      .N       (1),
      .W       (CNT_W),
      .RST_VEC (RST_LOAD)
   ) u_load_grp (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (load_we),
      .wr_data    (wr_data),
      .pol        (load_pol_q),
      .zero_evt   (zero_evt),
      .glb_arm    (arm_q),
      .active_q   (load_act_q),
      .active_nxt (load_nxt)
   );

   pwm_shadow_group #(
      .N       (NCMP),
      .W       (CNT_W),
      .RST_VEC ('0)
   ) u_cmp_grp (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (cmp_we),
      .wr_data    (wr_data),
      .pol        (cmp_pol_q),
      .zero_evt   (zero_evt),
      .glb_arm    (arm_q),
      .active_q   (cmp_act_q),
      .active_nxt (cmp_nxt)
   );

   pwm_timebase #(
      .W        (CNT_W),
      .RST_LOAD (RST_LOAD)
   ) u_tb (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload_val (load_nxt),
      .cnt_q      (cnt_q),
      .zero_evt   (zero_evt)
   );

   pwm_edge_out #(
      .W (CNT_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt      (cnt_q),
      .zero_evt (zero_evt),
      .cmp_a    (cmp_act_q[0 +: CNT_W]),
      .cmp_b    (cmp_act_q[CNT_W +: CNT_W]),
      .pwm_q    (pwm_out),
      .match_b  (match_b)
   );

   assign glb_pending = arm_q;
   assign cnt_out     = cnt_q;

   // R8: a request arms the pending flag
   a_r8_arm_set : assert property (@(posedge clk) disable iff (!rst_n)
      glb_req |=> glb_pending);

   // R8: the zero consumes the armed request
   a_r8_arm_clear : assert property (@(posedge clk) disable iff (!rst_n)
      (glb_pending && zero_evt && !glb_req) |=> !glb_pending);

   // R2: reload takes the period value that is active afterwards
   a_r2_reload_value : assert property (@(posedge clk) disable iff (!rst_n)
      zero_evt |=> (cnt_out == load_act_q));

   // R6: compare pair frozen mid-cycle under local policy
   a_r6_pair_frozen : assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_pol_q == POL_LOCAL && !zero_evt) |-> (cmp_nxt == cmp_act_q));

endmodule

// File: tb/pwm_gen_buffered_bench.sv
module pwm_gen_buffered_bench;

   localparam int         W    = 8;
   localparam logic [7:0] RSTL = 8'd9;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_addr = '0;
   logic [W-1:0] wr_data = '0;
   logic         glb_req = 1'b0;
   logic         pwm_out;
   logic         match_b;
   logic         glb_pending;
   logic [W-1:0] cnt_out;

   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   pwm_gen_buffered #(
      .CNT_W    (W),
      .RST_LOAD (RSTL)
   ) u_pwm_gen_buffered (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .glb_req     (glb_req),
      .pwm_out     (pwm_out),
      .match_b     (match_b),
      .glb_pending (glb_pending),
      .cnt_out     (cnt_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] a, input int d);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = W'(d);
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   task automatic pulse_glb();
      glb_req = 1'b1;
      @(negedge clk);
      glb_req = 1'b0;
   endtask

   task automatic wait_zero();
      @(negedge clk);
      while (cnt_out != '0) @(negedge clk);
   endtask

   task automatic wait_cnt(input int v);
      while (cnt_out != W'(v)) @(negedge clk);
   endtask

   // Called at a sample where the count is zero; covers one full cycle.
   task automatic measure(output int per, output int hi);
      per = 0;
      hi  = 0;
      do begin
         @(negedge clk);
         per++;
         if (pwm_out) hi++;
      end while (cnt_out != '0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      check(cnt_out == RSTL, "R1 count in reset", cnt_out, RSTL);
      check(pwm_out == 1'b0, "R1 output low", pwm_out, 0);
      check(glb_pending == 1'b0, "R1 no pending", glb_pending, 0);
      check(match_b == 1'b0, "R1 match_b low", match_b, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(cnt_out == RSTL - 1, "R1 first count after reset", cnt_out, RSTL - 1);
      check(pwm_out == 1'b0, "R1 output low after reset", pwm_out, 0);
   endtask

   task automatic t_immediate();
      int per, hi, c;
      reg_wr(2'd2, 4);                       // R5 compare A immediate
      wait_zero();
      measure(per, hi);
      check(per == 10, "R2 period reset load", per, 10);
      check(hi == 6, "R5 immediate compare A", hi, 6);
      @(negedge clk);
      reg_wr(2'd1, 5);                       // period written mid-cycle
      c = int'(cnt_out);
      @(negedge clk);
      check(int'(cnt_out) == c - 1, "R2 decrement", cnt_out, c - 1);
      per = 0;
      while (cnt_out != '0) begin @(negedge clk); per++; end
      check(per == c - 1, "R5 current cycle not cut", per, c - 1);
      measure(per, hi);
      check(per == 6, "R5 new period at reload", per, 6);
      check(hi == 2, "R3 high time", hi, 2);
   endtask

   task automatic t_match_b();
      reg_wr(2'd3, 3);
      wait_cnt(3);
      check(match_b == 1'b1, "R4 match at B", match_b, 1);
      @(negedge clk);
      check(match_b == 1'b0, "R4 no match off B", match_b, 0);
   endtask

   task automatic t_local();
      int per, hi;
      reg_wr(2'd1, 20);
      reg_wr(2'd0, 4);                       // compare policy local
      wait_zero();
      reg_wr(2'd2, 15);
      reg_wr(2'd3, 12);
      wait_cnt(12);
      check(match_b == 1'b0, "R6 B still old", match_b, 0);
      check(pwm_out == 1'b1, "R6 A still old", pwm_out, 1);
      wait_zero();
      wait_cnt(12);
      check(match_b == 1'b1, "R6 B new after zero", match_b, 1);
      check(pwm_out == 1'b0, "R6 A new after zero", pwm_out, 0);
      wait_zero();
      measure(per, hi);
      check(per == 21, "R2 period 20", per, 21);
      check(hi == 6, "R6 pair committed", hi, 6);
   endtask

   task automatic t_global();
      int per, hi;
      reg_wr(2'd0, 8);                       // compare policy global
      wait_zero();
      reg_wr(2'd2, 10);
      wait_zero();
      measure(per, hi);
      check(hi == 6, "R7 zero alone keeps old", hi, 6);
      check(glb_pending == 1'b0, "R8 idle", glb_pending, 0);
      @(negedge clk);
      pulse_glb();
      check(glb_pending == 1'b1, "R8 armed", glb_pending, 1);
      wait_cnt(12);
      check(pwm_out == 1'b0, "R7 armed alone keeps old", pwm_out, 0);
      wait_zero();
      check(glb_pending == 1'b1, "R8 still armed at zero", glb_pending, 1);
      @(negedge clk);
      check(glb_pending == 1'b0, "R8 cleared after zero", glb_pending, 0);
      wait_cnt(12);
      check(pwm_out == 1'b1, "R7 committed", pwm_out, 1);
      wait_zero();
      measure(per, hi);
      check(hi == 11, "R7 new high time", hi, 11);
   endtask

   task automatic t_last_write();
      int per, hi;
      reg_wr(2'd2, 5);
      reg_wr(2'd2, 8);
      pulse_glb();
      wait_zero();
      measure(per, hi);
      check(hi == 13, "R9 last write commits", hi, 13);
   endtask

   task automatic t_mixed();
      int per, hi;
      reg_wr(2'd0, 1);                       // period local, compare immediate
      reg_wr(2'd1, 12);
      reg_wr(2'd2, 3);
      wait_cnt(5);
      check(pwm_out == 1'b1, "R11 compare immediate", pwm_out, 1);
      wait_zero();
      measure(per, hi);
      check(per == 13, "R11 period local", per, 13);
      check(hi == 10, "R11 high time", hi, 10);
      reg_wr(2'd0, 12);                      // compare code 3
      reg_wr(2'd2, 7);
      wait_cnt(5);
      check(pwm_out == 1'b0, "R10 code 3 immediate", pwm_out, 0);
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_immediate();
      t_match_b();
      t_local();
      t_global();
      t_last_write();
      t_mixed();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule